// File: doc/BRIEF.md
# Four-Channel Sampled Glitch Filter

The block cleans four asynchronous input pins before they reach capture, encoder and timer logic. Two of the inputs are quadrature phase signals, one is an encoder index, and one is an external clock for a timer. Each pin is first passed through a two-stage synchronizer. All four channels then share one sampling strobe, which a programmable prescaler derives from the instruction-cycle tick. A channel moves its filtered level only after three successive strobes have all seen the same new level. A shorter burst of noise is discarded.

An 8-bit configuration register can be read and written. It holds one enable per channel and a 3-bit divider code. A channel whose enable is clear skips the filter and forwards its synchronized pin. The downstream logic sees the same enable behaviour in encoder mode and in capture mode, because the block has no mode input. After reset the register is zero, so every channel is bypassed and the divider is 1:1.

Top module: `pin_deglitch`

## Requirements
- R1: After reset `cfg_rdata` reads 0x00, every channel is in bypass, the divider code is 000, and each channel's held filter level is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]`, which appears on `cfg_rdata` after the next rising clock edge. Bit 7 always reads 0. The enable for channel k sits at bit 3+k (k = 0..3), and the divider code sits at bits 2:0.
- R3: When channel k's enable bit is 0, `pin_clean[k]` equals `pin_raw[k]` delayed by exactly two clock cycles.
- R4: When channel k's enable bit is 1, `pin_clean[k]` takes a new level only after three consecutive strobes have sampled that level. With code 000 and `cy_tick` held high, a step on the pin appears at the output five clock edges later.
- R5: A run of fewer than three strobes at the new level leaves the filtered output unchanged, because a matching sample clears the run count.
- R6: The strobe fires once per N qualified ticks. N is 1, 2, 4, 16, 32, 64 or 128 for codes 000, 001, 010, 011, 100, 101 and 110 respectively.
- R7: Code 111 stops the strobe. Every enabled channel then holds its filtered level whatever its pin does.
- R8: Any change of the divider code restarts the prescaler count from zero, and no strobe is issued in that cycle.
- R9: Each channel's enable selects filtered or bypass for that channel only. The other channels are not affected.
- R10: The prescaler advances only in cycles where `cy_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cy_tick | input | 1 | Instruction-cycle qualifier that feeds the prescaler |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data: enables in bits 6:3, divider code in bits 2:0 |
| cfg_rdata | output | 8 | Configuration register read-back, with bit 7 always 0 |
| pin_raw | input | 4 | Asynchronous input pins (index, phase A, phase B, timer clock) |
| pin_clean | output | 4 | Filtered or bypassed pin levels |

## Verification
The hardest state to reach is a divider-code change that lands in the middle of a long prescaler count while a channel is partway through a stability run. In that state the restart and the two-sample run count interact, and the port only shows the result many cycles later. The random phase writes new codes at random points while `cy_tick` is gated randomly and the pins flip slowly. A cycle-accurate bench model therefore meets mid-count restarts and part-finished runs under every ratio. Directed steps pin down the exact five-edge latency, the rejection of a two-sample glitch, and the hold under code 111.

// File: rtl/pin_deglitch_pkg.sv
package pin_deglitch_pkg;

    localparam int CODE_W  = 3;
    localparam int RATIO_W = 8;

    localparam logic [CODE_W-1:0] CODE_HALT = 3'b111;

    // Sampling ratio for each divider code; the halt code yields zero.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0:    r = 8'd1;
            3'd1:    r = 8'd2;
            3'd2:    r = 8'd4;
            3'd3:    r = 8'd16;
            3'd4:    r = 8'd32;
            3'd5:    r = 8'd64;
            3'd6:    r = 8'd128;
            default: r = 8'd0;
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [CODE_W-1:0]  code;
        logic               strobe;
    } strobe_state_t;

endpackage

// File: rtl/deglitch_strobe_gen.sv
module deglitch_strobe_gen
    import pin_deglitch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              strobe_o
);

    strobe_state_t st_d, st_q;
    logic [RATIO_W-1:0] ratio;

    always_comb begin
        ratio     = ratio_of(code_i);
        st_d      = st_q;
        st_d.code = code_i;
        st_d.strobe = 1'b0;
        if (code_i != st_q.code) begin
            st_d.cnt = '0;
        end else if (code_i != CODE_HALT && tick_i) begin
            if (st_q.cnt == ratio - 1'b1) begin
                st_d.cnt    = '0;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;

    AST_HALT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == CODE_HALT) |=> !strobe_o); // R7
    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !strobe_o); // R10
    AST_CODE_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i != st_q.code) |=> (st_q.cnt == '0 && !strobe_o)); // R8
    AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code != CODE_HALT) |-> (st_q.cnt < ratio_of(st_q.code))); // R6

endmodule

// File: rtl/deglitch_channel.sv
module deglitch_channel #(
    parameter int STABLE_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic strobe_i,
    input  logic en_i,
    output logic out_o
);

    localparam int RUN_W = $clog2(STABLE_N);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             held;
        logic [RUN_W-1:0] run;
    } chan_state_t;

    chan_state_t ch_d, ch_q;

    always_comb begin
        ch_d    = ch_q;
        ch_d.s1 = pin_i;
        ch_d.s2 = ch_q.s1;
        if (strobe_i) begin
            if (ch_q.s2 != ch_q.held) begin
                if (ch_q.run == RUN_W'(STABLE_N - 1)) begin
                    ch_d.held = ch_q.s2;
                    ch_d.run  = '0;
                end else begin
                    ch_d.run = ch_q.run + 1'b1;
                end
            end else begin
                ch_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign out_o = en_i ? ch_q.held : ch_q.s2;

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(ch_q.held)); // R4
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.run < RUN_W'(STABLE_N)); // R5
    AST_MATCH_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && ch_q.s2 == ch_q.held) |=> (ch_q.run == '0)); // R5

endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
    import pin_deglitch_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int STABLE_N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cy_tick,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    input  logic [N_CH-1:0] pin_raw,
    output logic [N_CH-1:0] pin_clean
);

    localparam int EN_LSB = CODE_W;
    localparam int USED_W = EN_LSB + N_CH;

    logic [USED_W-1:0] cfg_d, cfg_q;
    logic              strobe;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) cfg_d = cfg_wdata[USED_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_rdata = 8'(cfg_q);

    deglitch_strobe_gen u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (cy_tick),
        .code_i   (cfg_q[CODE_W-1:0]),
        .strobe_o (strobe)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        deglitch_channel #(.STABLE_N(STABLE_N)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_raw[k]),
            .strobe_i (strobe),
            .en_i     (cfg_q[EN_LSB+k]),
            .out_o    (pin_clean[k])
        );
    end

    AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0); // R2
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[6:0] == $past(cfg_wdata[6:0]))); // R2

endmodule

// File: tb/sim_pin_deglitch.sv
module sim_pin_deglitch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cy_tick = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [3:0] pin_raw = 4'h0;
    logic [3:0] pin_clean;

    always #2.5 clk = ~clk;

    pin_deglitch u0 (
        .clk(clk), .rst_n(rst_n), .cy_tick(cy_tick), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_raw(pin_raw), .pin_clean(pin_clean)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    bit    model_on = 0;
    string cur_req = "R1";

    // Reference model derived from the requirements.
    logic [7:0] m_cfg;
    logic [3:0] m_s1, m_s2, m_held;
    logic [1:0] m_run [4];
    logic [7:0] m_pc;
    logic [2:0] m_code;
    logic       m_stb;

    function automatic logic [7:0] exp_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 8'd1;
            3'd1: return 8'd2;
            3'd2: return 8'd4;
            3'd3: return 8'd16;
            3'd4: return 8'd32;
            3'd5: return 8'd64;
            3'd6: return 8'd128;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_out();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = m_cfg[3+i] ? m_held[i] : m_s2[i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg <= 0; m_s1 <= 0; m_s2 <= 0; m_held <= 0;
            m_pc <= 0; m_code <= 0; m_stb <= 0;
            for (int i = 0; i < 4; i++) m_run[i] <= 0;
        end else begin
            if (cfg_we) m_cfg <= {1'b0, cfg_wdata[6:0]};
            m_s1 <= pin_raw;
            m_s2 <= m_s1;
            m_code <= m_cfg[2:0];
            m_stb <= 1'b0;
            if (m_cfg[2:0] != m_code) m_pc <= 0;
            else if (m_cfg[2:0] != 3'b111 && cy_tick) begin
                if (m_pc == exp_ratio(m_cfg[2:0]) - 8'd1) begin
                    m_pc <= 0; m_stb <= 1'b1;
                end else m_pc <= m_pc + 8'd1;
            end
            for (int i = 0; i < 4; i++) begin
                if (m_stb) begin
                    if (m_s2[i] != m_held[i]) begin
                        if (m_run[i] == 2'd2) begin
                            m_held[i] <= m_s2[i]; m_run[i] <= 0;
                        end else m_run[i] <= m_run[i] + 2'd1;
                    end else m_run[i] <= 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            chk(pin_clean == exp_out(), cur_req, pin_clean, exp_out());
            chk(cfg_rdata == m_cfg, cur_req, cfg_rdata, m_cfg);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);
        chk(pin_clean == 4'h0, "R1", pin_clean, 0);
        model_on = 1;

        cur_req = "R2";
        wr(8'hFF);
        chk(cfg_rdata == 8'h7F, "R2", cfg_rdata, 8'h7F);
        wr(8'h00);
        chk(cfg_rdata == 8'h00, "R2", cfg_rdata, 0);

        // R3 bypass latency of two edges
        cur_req = "R3";
        pin_raw[1] = 1'b1;
        step(1);
        chk(pin_clean[1] == 1'b0, "R3", pin_clean[1], 0);
        step(1);
        chk(pin_clean[1] == 1'b1, "R3", pin_clean[1], 1);

        // R4 filtered step appears after five edges (code 000, tick high)
        cur_req = "R4";
        wr(8'h08);
        step(4);
        pin_raw[0] = 1'b1;
        step(4);
        chk(pin_clean[0] == 1'b0, "R4", pin_clean[0], 0);
        step(1);
        chk(pin_clean[0] == 1'b1, "R4", pin_clean[0], 1);

        // R5 two-sample glitch rejected
        cur_req = "R5";
        pin_raw[0] = 1'b0;
        step(2);
        pin_raw[0] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step(1);
            chk(pin_clean[0] == 1'b1, "R5", pin_clean[0], 1);
        end

        // R7 halt code freezes filtered level
        cur_req = "R7";
        wr(8'h0F);
        pin_raw[0] = 1'b0;
        step(20);
        chk(pin_clean[0] == 1'b1, "R7", pin_clean[0], 1);
        wr(8'h08);
        step(10);
        chk(pin_clean[0] == 1'b0, "R7", pin_clean[0], 0);

        // R9 a neighbour's enable does not touch a bypassed channel
        cur_req = "R9";
        pin_raw[2] = 1'b1;
        step(2);
        chk(pin_clean[2] == 1'b1, "R9", pin_clean[2], 1);
        chk(pin_clean[0] == 1'b0, "R9", pin_clean[0], 0);

        // R6 every ratio, checked by the model each cycle
        cur_req = "R6";
        for (int c = 0; c < 7; c++) begin
            wr({1'b0, 4'hF, 3'(c)});
            for (int t = 0; t < 600; t++) begin
                if ($urandom_range(0, 99) < 2) pin_raw = pin_raw ^ 4'($urandom_range(1, 15));
                step(1);
            end
        end

        // R8 / R10 random code changes with gated ticks
        for (int t = 0; t < 20000; t++) begin
            cur_req = (t % 2 == 0) ? "R8" : "R10";
            cy_tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 149) == 0) begin
                cfg_we = 1'b1;
                cfg_wdata = 8'($urandom_range(0, 255));
            end else cfg_we = 1'b0;
            if ($urandom_range(0, 29) == 0) pin_raw = pin_raw ^ 4'($urandom_range(1, 15));
            if ($urandom_range(0, 299) == 0) pin_raw[3] = ~pin_raw[3];
            step(1);
        end
        cfg_we = 1'b0;
        cur_req = "R9";
        wr(8'h50);
        step(300);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule